// File: doc/BRIEF.md
# RapidIO Read-Request Responder

This block answers RapidIO read requests. A parsed request header arrives as one word on a ready/valid receive bus. When the header is a read request with 16-bit device IDs, the block records the fields it needs and turns away further headers. It then sends back one response packet on a 128-bit ready/valid transmit stream, with start-of-packet, end-of-packet, empty-byte count and packet-size sideband.

The response header swaps the two device IDs, keeps the transaction ID and raises the priority by one step. It fills the top eight bytes of the first beat. The requested bytes come from an internal pattern store and follow the header most-significant byte first. The last beat carries an exact count of its unused low-order bytes. A header that is not a read request is taken and discarded. A read with a size encoding the block does not support gets a one-beat error response.

Top module: `rioReadResponder`

## Requirements
- R1: A header is taken on a clock edge where hdrValid and hdrReady are both high. hdrReady is high whenever no response is in progress. It drops on the cycle after a read request is taken and stays low until the edge on which the final beat is handed over.
- R2: A response is produced only when hdrData[99:96] is 4'b0010, hdrData[63:60] is 4'b0100 and hdrData[101:100] is 2'b01. Any other header is consumed, no transmit beat follows, and hdrReady stays high.
- R3: The first beat holds the response header in bits [127:64]. These fields are fixed: bits [127:120] zero (ackID, VC, CRF), [117:116] = 2'b01, [115:112] = 4'hD. For a supported size, [79:76] = 4'b1000 and [75:72] = 4'b0000.
- R4: Response bits [111:96] equal request source ID hdrData[79:64]. Response bits [95:80] equal request destination ID hdrData[95:80]. Response bits [71:64] equal transaction ID hdrData[55:48].
- R5: Response priority [119:118] is the request priority hdrData[103:102] plus one, saturating at 2'b11.
- R6: Size hdrData[59:56] and wdptr hdrData[18] decode to a byte count: 4'b1011 with wdptr 0 gives 8, 4'b1011 with wdptr 1 gives 16, 4'b1100 with wdptr 0 gives 32, and 4'b1100 with wdptr 1 gives 64.
- R7: Packet byte i sits in beat i/16, in lane i%16, where lane 0 is bits [127:120]. Bytes 0 to 7 are the header. Payload byte k is ((A + k) mod 256) XOR 8'hA5, where A = {hdrData[23:19], 3'b000}.
- R8: txPacketSize equals 8 plus the payload byte count on every beat of the packet.
- R9: A packet has ceil(size/16) beats. txSop is high on the first beat only and txEop on the last beat only. txEmpty is 16*beats - size on the last beat and 0 on every other beat. Lanes past the end of the packet are zero.
- R10: While txValid is high and txReady is low, txData, txSop, txEop, txEmpty and txPacketSize do not change and txValid stays high.
- R11: A read with any other size/wdptr combination gets a one-beat response. It has ttype 4'b0000, status 4'b0111, txPacketSize 8 and txEmpty 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Request header present |
| hdrReady | output | 1 | Block can take a header |
| hdrData | input | 115 | Parsed request header |
| txValid | output | 1 | Transmit beat present |
| txReady | input | 1 | Downstream takes the beat |
| txData | output | 128 | Transmit beat, byte lane 0 in the top bits |
| txSop | output | 1 | First beat of packet |
| txEop | output | 1 | Last beat of packet |
| txEmpty | output | 4 | Unused low-order bytes on the last beat |
| txPacketSize | output | 8 | Packet length in bytes |

## Verification
Read requests cover every supported size: 8, 16, 32 and 64 bytes. These separate the beat-count and empty-count arithmetic at a one-beat, two-beat, three-beat and five-beat boundary. Priorities 0 to 3 show the one-step raise apart from the saturation case. A base address near the top of the low byte shows that payload numbering wraps. Headers that differ from a read in only one field each (ftype, ttype or tt) show that each match term is needed. An unsupported size shows the error encoding. Stalled beats show that the data is held, and a reset in the middle of a packet shows that the stream aborts cleanly.

// File: rtl/rioRspPkg.sv
package rioRspPkg;
  typedef struct packed {
    logic load;
    logic advance;
  } ctrlStrobes_t;

  function automatic logic [6:0] decodeBytes(input logic [3:0] sz, input logic wd);
    logic [6:0] n;
    n = 7'd0;
    if (sz == 4'b1011) n = wd ? 7'd16 : 7'd8;
    else if (sz == 4'b1100) n = wd ? 7'd64 : 7'd32;
    return n;
  endfunction

  function automatic logic [1:0] bumpPrio(input logic [1:0] p);
    return (p == 2'b11) ? 2'b11 : p + 2'b01;
  endfunction
endpackage

// File: rtl/rspControl.sv
module rspControl
  import rioRspPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hdrValid,
  input  logic         reqIsRead,
  input  logic         txReady,
  input  logic         firstBeat,
  input  logic         lastBeat,
  output logic         hdrReady,
  output logic         txValid,
  output logic         txSop,
  output logic         txEop,
  output ctrlStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;
  state_t state;

  assign hdrReady        = (state == ST_IDLE);
  assign txValid         = (state == ST_SEND);
  assign strobes.load    = hdrValid && hdrReady && reqIsRead;
  assign strobes.advance = txValid && txReady;
  assign txSop           = txValid && firstBeat;
  assign txEop           = txValid && lastBeat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (strobes.load) state <= ST_SEND;
        ST_SEND: if (strobes.advance && lastBeat) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rspDatapath.sv
module rspDatapath
  import rioRspPkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int HDR_W   = 115,
  parameter logic [7:0] PATTERN = 8'hA5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [HDR_W-1:0]           hdrData,
  output logic                       reqIsRead,
  output logic                       firstBeat,
  output logic                       lastBeat,
  output logic [DATA_W-1:0]          txData,
  output logic [$clog2(DATA_W/8)-1:0] emptyLast,
  output logic [7:0]                 txPacketSize
);
  localparam int LANES     = DATA_W / 8;
  localparam int HDR_BYTES = 8;
  localparam int MAX_BEATS = (HDR_BYTES + 64 + LANES - 1) / LANES;
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
  localparam int EMPTY_W   = $clog2(LANES);

  logic [63:0]       rspHdr;
  logic [7:0]        baseLow;
  logic [7:0]        totalBytes;
  logic [BEAT_W-1:0] beatIdx;
  logic [7:0]        numBeats;
  logic [6:0]        reqBytes;

  assign reqIsRead = (hdrData[99:96] == 4'b0010) && (hdrData[63:60] == 4'b0100) &&
                     (hdrData[101:100] == 2'b01);
  assign reqBytes  = decodeBytes(hdrData[59:56], hdrData[18]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHdr     <= '0;
      baseLow    <= '0;
      totalBytes <= 8'(HDR_BYTES);
      beatIdx    <= '0;
    end else if (strobes.load) begin
      rspHdr     <= {8'h00, bumpPrio(hdrData[103:102]), 2'b01, 4'hD,
                     hdrData[79:64], hdrData[95:80],
                     (reqBytes != 0) ? 4'b1000 : 4'b0000,
                     (reqBytes != 0) ? 4'b0000 : 4'b0111,
                     hdrData[55:48]};
      baseLow    <= {hdrData[23:19], 3'b000};
      totalBytes <= 8'(HDR_BYTES) + {1'b0, reqBytes};
      beatIdx    <= '0;
    end else if (strobes.advance) begin
      beatIdx    <= beatIdx + 1'b1;
    end
  end

  assign numBeats     = (totalBytes + 8'(LANES - 1)) >> $clog2(LANES);
  assign firstBeat    = (beatIdx == '0);
  assign lastBeat     = (8'(beatIdx) == numBeats - 8'd1);
  assign emptyLast    = EMPTY_W'(numBeats * 8'(LANES) - totalBytes);
  assign txPacketSize = totalBytes;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [7:0] idx;
    logic [7:0] laneByte;
    assign idx = 8'(beatIdx) * 8'(LANES) + 8'(j);
    always_comb begin
      if (idx < 8'(HDR_BYTES))
        laneByte = rspHdr[8*(7 - idx[2:0]) +: 8];
      else if (idx < totalBytes)
        laneByte = (baseLow + idx - 8'(HDR_BYTES)) ^ PATTERN;
      else
        laneByte = 8'h00;
    end
    assign txData[DATA_W-1-8*j -: 8] = laneByte;
  end
endmodule

// File: rtl/rioReadResponder.sv
module rioReadResponder
  import rioRspPkg::*;
#(
  parameter int DATA_W = 128,
  parameter int HDR_W  = 115
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hdrValid,
  output logic                        hdrReady,
  input  logic [HDR_W-1:0]            hdrData,
  output logic                        txValid,
  input  logic                        txReady,
  output logic [DATA_W-1:0]           txData,
  output logic                        txSop,
  output logic                        txEop,
  output logic [$clog2(DATA_W/8)-1:0] txEmpty,
  output logic [7:0]                  txPacketSize
);
  ctrlStrobes_t strobes;
  logic reqIsRead, firstBeat, lastBeat;
  logic [$clog2(DATA_W/8)-1:0] emptyLast;

  rspControl u_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .reqIsRead(reqIsRead),
    .txReady(txReady), .firstBeat(firstBeat), .lastBeat(lastBeat),
    .hdrReady(hdrReady), .txValid(txValid), .txSop(txSop), .txEop(txEop),
    .strobes(strobes)
  );

  rspDatapath #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hdrData(hdrData),
    .reqIsRead(reqIsRead), .firstBeat(firstBeat), .lastBeat(lastBeat),
    .txData(txData), .emptyLast(emptyLast), .txPacketSize(txPacketSize)
  );

  assign txEmpty = txEop ? emptyLast : '0;
endmodule

// File: rtl/rioReadResponderChecker.sv
module rioReadResponderChecker #(
  parameter int DATA_W = 128,
  parameter int HDR_W  = 115
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        hdrValid,
  input logic                        hdrReady,
  input logic [HDR_W-1:0]            hdrData,
  input logic                        txValid,
  input logic                        txReady,
  input logic [DATA_W-1:0]           txData,
  input logic                        txSop,
  input logic                        txEop,
  input logic [$clog2(DATA_W/8)-1:0] txEmpty,
  input logic [7:0]                  txPacketSize
);
  logic readLike;
  assign readLike = (hdrData[99:96] == 4'b0010) && (hdrData[63:60] == 4'b0100) &&
                    (hdrData[101:100] == 2'b01);

  // R10
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txSop) &&
    $stable(txEop) && $stable(txEmpty) && $stable(txPacketSize));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !hdrReady);

  // R2
  start_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && hdrReady && readLike |=> txValid && txSop);

  // R2
  drop_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && hdrReady && !readLike |=> !txValid && hdrReady);

  // R9
  end_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && txEop |=> !txValid && hdrReady);

  // R9
  empty_only_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txEop |-> txEmpty == '0);

  // R8
  size_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txPacketSize >= 8'd8) && (txPacketSize <= 8'd72));
endmodule

bind rioReadResponder rioReadResponderChecker #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_chk (.*);

// File: tb/sim_rioReadResponder.sv
`timescale 1ns/1ps
module sim_rioReadResponder;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hdrValid = 1'b0;
  logic         hdrReady;
  logic [114:0] hdrData = '0;
  logic         txValid;
  logic         txReady = 1'b1;
  logic [127:0] txData;
  logic         txSop, txEop;
  logic [3:0]   txEmpty;
  logic [7:0]   txPacketSize;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rioReadResponder u0 (.*);

  typedef struct packed {
    logic [1:0]  prio;
    logic [1:0]  tt;
    logic [3:0]  ftype;
    logic [3:0]  ttype;
    logic [3:0]  size;
    logic        wd;
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  tid;
    logic [28:0] addr;
    logic        stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'b01, 4'h2, 4'h4, 4'hC, 1'b0, 16'h00AA, 16'h00DD, 8'hBB, {28'h7654321, 1'b0}, 1'b0},
    '{2'd0, 2'b01, 4'h2, 4'h4, 4'hB, 1'b0, 16'h1234, 16'h5678, 8'h01, 29'h0000_0003, 1'b1},
    '{2'd2, 2'b01, 4'h2, 4'h4, 4'hB, 1'b1, 16'hBEEF, 16'hCAFE, 8'h7E, 29'h0000_0010, 1'b0},
    '{2'd3, 2'b01, 4'h2, 4'h4, 4'hC, 1'b1, 16'h0F0F, 16'hF0F0, 8'h42, 29'h0000_0007, 1'b1},
    '{2'd1, 2'b01, 4'h2, 4'h4, 4'h5, 1'b0, 16'h0101, 16'h0202, 8'h99, 29'h0000_0000, 1'b0},
    '{2'd1, 2'b01, 4'h5, 4'h4, 4'hC, 1'b0, 16'h0303, 16'h0404, 8'h10, 29'h0000_0000, 1'b0},
    '{2'd1, 2'b01, 4'h2, 4'h1, 4'hC, 1'b0, 16'h0505, 16'h0606, 8'h11, 29'h0000_0000, 1'b0},
    '{2'd1, 2'b00, 4'h2, 4'h4, 4'hC, 1'b0, 16'h0707, 16'h0808, 8'h12, 29'h0000_0000, 1'b0},
    '{2'd0, 2'b01, 4'h2, 4'h4, 4'hC, 1'b0, 16'h0909, 16'h0A0A, 8'h13, 29'h0000_001F, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [114:0] mkHdr(input vec_t v);
    logic [114:0] h;
    h = '0;
    h[103:102] = v.prio;
    h[101:100] = v.tt;
    h[99:96]   = v.ftype;
    h[95:80]   = v.dst;
    h[79:64]   = v.src;
    h[63:60]   = v.ttype;
    h[59:56]   = v.size;
    h[55:48]   = v.tid;
    h[47:19]   = v.addr;
    h[18]      = v.wd;
    return h;
  endfunction

  // R6 decode as the requirement states it
  function automatic int payLen(input vec_t v);
    if (v.size == 4'hB) return v.wd ? 16 : 8;
    if (v.size == 4'hC) return v.wd ? 64 : 32;
    return 0;
  endfunction

  function automatic logic [63:0] expHdr(input vec_t v);
    logic [1:0] p;
    bit ok;
    p = (v.prio == 2'd3) ? 2'd3 : v.prio + 2'd1;
    ok = payLen(v) != 0;
    return {8'h00, p, 2'b01, 4'hD, v.src, v.dst, ok ? 4'h8 : 4'h0, ok ? 4'h0 : 4'h7, v.tid};
  endfunction

  function automatic logic [127:0] expBeat(input vec_t v, input int b);
    logic [127:0] d;
    logic [63:0]  h;
    logic [7:0]   a;
    int total, i;
    h = expHdr(v);
    total = 8 + payLen(v);
    a = {v.addr[4:0], 3'b000};
    d = '0;
    for (int j = 0; j < 16; j++) begin
      i = b * 16 + j;
      if (i < 8) d[127-8*j -: 8] = h[63-8*i -: 8];
      else if (i < total) d[127-8*j -: 8] = (a + 8'(i - 8)) ^ 8'hA5;
    end
    return d;
  endfunction

  task automatic checkBeat(input vec_t v, input int b, input string tag);
    int total, beats, empty;
    total = 8 + payLen(v);
    beats = (total + 15) / 16;
    empty = beats * 16 - total;
    check(txValid === 1'b1, {tag, " R9 valid"}, 128'(txValid), 128'd1);
    check(txSop === (b == 0), {tag, " R9 sop"}, 128'(txSop), 128'(b == 0));
    check(txEop === (b == beats - 1), {tag, " R9 eop"}, 128'(txEop), 128'(b == beats - 1));
    check(txEmpty === ((b == beats - 1) ? 4'(empty) : 4'd0), {tag, " R9 empty"},
          128'(txEmpty), 128'((b == beats - 1) ? empty : 0));
    check(txPacketSize === 8'(total), {tag, " R8 size"}, 128'(txPacketSize), 128'(total));
    check(txData === expBeat(v, b), {tag, " R3 R4 R5 R7 R11 data"}, txData, expBeat(v, b));
    check(hdrReady === 1'b0, {tag, " R1 busy"}, 128'(hdrReady), 128'd0);
  endtask

  task automatic runVec(input vec_t v);
    bit isRead;
    int beats;
    logic [127:0] held;
    isRead = (v.ftype == 4'h2) && (v.ttype == 4'h4) && (v.tt == 2'b01);
    beats = (8 + payLen(v) + 15) / 16;
    @(negedge clk);
    hdrData = mkHdr(v);
    hdrValid = 1'b1;
    check(hdrReady === 1'b1, "R1 ready idle", 128'(hdrReady), 128'd1);
    @(negedge clk);
    hdrValid = 1'b0;
    if (!isRead) begin
      for (int k = 0; k < 3; k++) begin
        check(txValid === 1'b0, "R2 dropped no beat", 128'(txValid), 128'd0);
        check(hdrReady === 1'b1, "R2 dropped ready", 128'(hdrReady), 128'd1);
        @(negedge clk);
      end
      return;
    end
    for (int b = 0; b < beats; b++) begin
      if (v.stall) begin
        txReady = 1'b0;
        held = txData;
        @(negedge clk);
        check(txValid === 1'b1 && txData === held, "R10 held", txData, held);
        checkBeat(v, b, "R10 stalled");
      end
      txReady = 1'b1;
      checkBeat(v, b, "beat");
      @(negedge clk);
    end
    check(txValid === 1'b0, "R9 end valid", 128'(txValid), 128'd0);
    check(hdrReady === 1'b1, "R1 ready after", 128'(hdrReady), 128'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txValid === 1'b0, "R1 reset valid", 128'(txValid), 128'd0);
    check(hdrReady === 1'b1, "R1 reset ready", 128'(hdrReady), 128'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(txValid === 1'b0, "R1 post reset valid", 128'(txValid), 128'd0);

    for (int n = 0; n < NV; n++) runVec(VECS[n]);

    // reset part-way through a 32-byte response
    @(negedge clk);
    hdrData = mkHdr(VECS[0]);
    hdrValid = 1'b1;
    @(negedge clk);
    hdrValid = 1'b0;
    checkBeat(VECS[0], 0, "R9 pre-abort");
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(txValid === 1'b0, "R1 abort valid", 128'(txValid), 128'd0);
    check(hdrReady === 1'b1, "R1 abort ready", 128'(hdrReady), 128'd1);
    rstN = 1'b1;
    runVec(VECS[2]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule